// File: doc/BRIEF.md
# Shared Control Register Bank with Atomic Bit Aliases

This block holds a small set of 32-bit control registers that several bus masters update together. Each master has its own single-cycle request port. Besides a plain full-word write, each register can be reached through two address aliases. One alias sets a single bit and the other clears a single bit. The number of the bit to change travels in the write data. Because the block itself does the update, masters that share a register never need a read-modify-write sequence, so no update can be lost to a race.

Only accesses flagged as secure may write. Any master may read at any privilege level. A parameter mask marks registers as read-only, and a second mask marks registers that accept plain writes only and refuse the bit aliases. Every rejected access leaves all registers unchanged and returns an error flag. The response arrives one cycle after the request.

Top module: `alias_regbank`

## Requirements
- R1: On an active-low synchronous reset, every register reads 0 and no response is valid.
- R2: A secure write with address bits 15:14 = 00 to a mapped writable register stores the whole data word and returns no error. Register i sits at byte offset 4*i, and address bits 1:0 are ignored.
- R3: A secure write with address bits 15:14 = 11 sets the bit numbered by the write data, leaves every other bit unchanged and returns no error.
- R4: A secure write with address bits 15:14 = 10 clears the bit numbered by the write data, leaves every other bit unchanged and returns no error.
- R5: A set or clear alias write whose data is 32 or more changes nothing and returns an error.
- R6: Registers in the plain-only mask (register 6 by default) accept plain writes, but refuse set and clear aliases with an error and no change.
- R7: A write without the secure flag changes no register and returns an error. A read without the secure flag returns the register value with no error.
- R8: Registers in the read-only mask (register 7 by default) stay 0. Any write to them returns an error.
- R9: A read through the set or clear alias returns the underlying register. Any access with bits 15:14 = 01, or to a register index at or beyond the register count, returns an error. A read that errors returns data 0, and a write that errors changes nothing.
- R10: A response is valid in exactly the cycle after its request. A read in the same cycle as a write to the same register returns the value from before the write.
- R11: Updates from several masters in one cycle are applied in master order, master 0 first. Two alias writes to one register therefore both take effect. For two plain writes to one register, the highest-numbered master's value remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | NM | Request strobe per master |
| m_write | input | NM | 1 = write, 0 = read |
| m_secure | input | NM | Access carries the secure flag |
| m_addr | input | NM x 16 | Byte address; bits 15:14 select the alias |
| m_wdata | input | NM x 32 | Write data, or the bit index for an alias write |
| rsp_valid | output | NM | Response strobe, one cycle after the request |
| rsp_err | output | NM | Request was rejected |
| rsp_rdata | output | NM x 32 | Read data; 0 for writes and for rejected reads |

## Verification
The bound checker watches a set of properties on every cycle:
- Each response appears one cycle after its request, and never without one.
- A write without the secure flag draws an error.
- An alias write with an oversized bit index draws an error.
- Read-only registers stay at zero.
- No register moves in a cycle without a secure write.
- An erroring response carries zero data.

Other behaviour depends on specific values and orderings, and only the directed scenarios can show it:
- The exact bit pattern after a set or clear.
- The refusal of aliases on the plain-only register.
- Alias reads that return the underlying register.
- Pre-write read data in a cycle with a colliding write.
- The master-order merge of same-cycle updates.

// File: rtl/alias_regbank_pkg.sv
`timescale 1ns/1ps
package alias_regbank_pkg;
    localparam int WORD_W = 32;
    localparam int BIT_W  = 5;
    localparam int ADDR_W = 16;

    // alias selector, taken from address bits 15:14
    localparam logic [1:0] SEL_PLAIN = 2'b00;
    localparam logic [1:0] SEL_RSVD  = 2'b01;
    localparam logic [1:0] SEL_CLR   = 2'b10;
    localparam logic [1:0] SEL_SET   = 2'b11;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE,
        OP_SET,
        OP_CLR,
        OP_REJECT
    } op_e;
endpackage

// File: rtl/rb_decode.sv
`timescale 1ns/1ps
module rb_decode
    import alias_regbank_pkg::*;
#(
    parameter int             NR           = 8,
    parameter int             IDX_W        = 3,
    parameter logic [NR-1:0]  RO_MASK      = '0,
    parameter logic [NR-1:0]  NOALIAS_MASK = '0
) (
    input  logic              valid,
    input  logic              write,
    input  logic              secure,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output op_e               op,
    output logic [IDX_W-1:0]  idx,
    output logic [BIT_W-1:0]  bitn,
    output logic              err
);
    localparam logic [12:0] LIMIT = 13'(NR);

    logic [1:0]  sel;
    logic [11:0] word_idx;
    logic        mapped;
    logic        big_index;
    logic        unused_lo;

    assign sel       = addr[15:14];
    assign word_idx  = addr[13:2];
    assign mapped    = {1'b0, word_idx} < LIMIT;
    assign big_index = |wdata[WORD_W-1:BIT_W];
    assign unused_lo = ^addr[1:0];

    always_comb begin
        op   = OP_NONE;
        err  = 1'b0;
        idx  = word_idx[IDX_W-1:0];
        bitn = wdata[BIT_W-1:0];
        if (valid) begin
            if (!write) begin
                op  = OP_READ;
                err = !mapped || (sel == SEL_RSVD);
            end else if (!secure || !mapped || (sel == SEL_RSVD)) begin
                op  = OP_REJECT;
                err = 1'b1;
            end else if (RO_MASK[idx]) begin
                op  = OP_REJECT;
                err = 1'b1;
            end else if (sel == SEL_PLAIN) begin
                op  = OP_WRITE;
            end else if (NOALIAS_MASK[idx] || big_index) begin
                op  = OP_REJECT;
                err = 1'b1;
            end else begin
                op  = (sel == SEL_SET) ? OP_SET : OP_CLR;
            end
        end
    end
endmodule

// File: rtl/rb_apply.sv
`timescale 1ns/1ps
module rb_apply
    import alias_regbank_pkg::*;
#(
    parameter int NR    = 8,
    parameter int NM    = 2,
    parameter int IDX_W = 3
) (
    input  logic [NR-1:0][WORD_W-1:0] regs_in,
    input  op_e                       ops   [NM],
    input  logic [NM-1:0][IDX_W-1:0]  idx,
    input  logic [NM-1:0][BIT_W-1:0]  bitn,
    input  logic [NM-1:0][WORD_W-1:0] wdata,
    output logic [NR-1:0][WORD_W-1:0] regs_out
);
    // masters applied in index order: later ones see earlier results
    always_comb begin
        regs_out = regs_in;
        for (int m = 0; m < NM; m++) begin
            case (ops[m])
                OP_WRITE: regs_out[idx[m]]          = wdata[m];
                OP_SET:   regs_out[idx[m]][bitn[m]] = 1'b1;
                OP_CLR:   regs_out[idx[m]][bitn[m]] = 1'b0;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/alias_regbank.sv
`timescale 1ns/1ps
module alias_regbank
    import alias_regbank_pkg::*;
#(
    parameter int            NR           = 8,
    parameter int            NM           = 2,
    parameter logic [NR-1:0] RO_MASK      = 8'b1000_0000,
    parameter logic [NR-1:0] NOALIAS_MASK = 8'b0100_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NM-1:0]             m_valid,
    input  logic [NM-1:0]             m_write,
    input  logic [NM-1:0]             m_secure,
    input  logic [NM-1:0][ADDR_W-1:0] m_addr,
    input  logic [NM-1:0][WORD_W-1:0] m_wdata,
    output logic [NM-1:0]             rsp_valid,
    output logic [NM-1:0]             rsp_err,
    output logic [NM-1:0][WORD_W-1:0] rsp_rdata
);
    localparam int IDX_W = (NR > 1) ? $clog2(NR) : 1;

    typedef struct packed {
        logic [NR-1:0][WORD_W-1:0] regs;
        logic [NM-1:0]             vld;
        logic [NM-1:0]             err;
        logic [NM-1:0][WORD_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    op_e                       dec_op  [NM];
    logic [NM-1:0][IDX_W-1:0]  dec_idx;
    logic [NM-1:0][BIT_W-1:0]  dec_bit;
    logic [NM-1:0]             dec_err;
    logic [NR-1:0][WORD_W-1:0] regs_upd;
    logic [NR-1:0][WORD_W-1:0] regs_view;

    for (genvar g = 0; g < NM; g++) begin : g_port
        rb_decode #(
            .NR(NR), .IDX_W(IDX_W),
            .RO_MASK(RO_MASK), .NOALIAS_MASK(NOALIAS_MASK)
        ) u_dec (
            .valid  (m_valid[g]),
            .write  (m_write[g]),
            .secure (m_secure[g]),
            .addr   (m_addr[g]),
            .wdata  (m_wdata[g]),
            .op     (dec_op[g]),
            .idx    (dec_idx[g]),
            .bitn   (dec_bit[g]),
            .err    (dec_err[g])
        );
    end

    rb_apply #(.NR(NR), .NM(NM), .IDX_W(IDX_W)) u_apply (
        .regs_in  (st_q.regs),
        .ops      (dec_op),
        .idx      (dec_idx),
        .bitn     (dec_bit),
        .wdata    (m_wdata),
        .regs_out (regs_upd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.regs = regs_upd;
        for (int m = 0; m < NM; m++) begin
            st_d.vld[m]   = m_valid[m];
            st_d.err[m]   = dec_err[m];
            st_d.rdata[m] = (dec_op[m] == OP_READ && !dec_err[m])
                          ? st_q.regs[dec_idx[m]] : '0;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_err   = st_q.err;
    assign rsp_rdata = st_q.rdata;
    assign regs_view = st_q.regs;
endmodule

// File: rtl/rb_checker.sv
`timescale 1ns/1ps
module rb_checker
    import alias_regbank_pkg::*;
#(
    parameter int            NR      = 8,
    parameter int            NM      = 2,
    parameter logic [NR-1:0] RO_MASK = '0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NM-1:0]             m_valid,
    input logic [NM-1:0]             m_write,
    input logic [NM-1:0]             m_secure,
    input logic [NM-1:0][ADDR_W-1:0] m_addr,
    input logic [NM-1:0][WORD_W-1:0] m_wdata,
    input logic [NM-1:0]             rsp_valid,
    input logic [NM-1:0]             rsp_err,
    input logic [NM-1:0][WORD_W-1:0] rsp_rdata,
    input logic [NR-1:0][WORD_W-1:0] regs
);
    logic unused_bits;
    assign unused_bits = ^{m_addr, m_wdata};

    for (genvar g = 0; g < NM; g++) begin : g_m
        AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            m_valid[g] |=> rsp_valid[g]); // R10
        AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
            !m_valid[g] |=> !rsp_valid[g]); // R10
        AST_INSECURE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[g] && m_write[g] && !m_secure[g]) |=> rsp_err[g]); // R7
        AST_WIDE_INDEX_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[g] && m_write[g] && m_addr[g][15] && (|m_wdata[g][WORD_W-1:BIT_W]))
            |=> rsp_err[g]); // R5
        AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid[g] && rsp_err[g]) |-> (rsp_rdata[g] == '0)); // R9
    end

    AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(m_valid & m_write & m_secure)) |=> $stable(regs)); // R7

    for (genvar i = 0; i < NR; i++) begin : g_r
        if (RO_MASK[i]) begin : g_ro
            AST_RO_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                m_valid[0] || !m_valid[0] |-> regs[i] == '0); // R8
        end
    end
endmodule

bind alias_regbank rb_checker #(.NR(NR), .NM(NM), .RO_MASK(RO_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_valid   (m_valid),
    .m_write   (m_write),
    .m_secure  (m_secure),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .regs      (regs_view)
);

// File: tb/alias_regbank_test.sv
`timescale 1ns/1ps
module alias_regbank_test;
    localparam int NM = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NM-1:0]        m_valid = '0;
    logic [NM-1:0]        m_write = '0;
    logic [NM-1:0]        m_secure = '0;
    logic [NM-1:0][15:0]  m_addr = '0;
    logic [NM-1:0][31:0]  m_wdata = '0;
    logic [NM-1:0]        rsp_valid;
    logic [NM-1:0]        rsp_err;
    logic [NM-1:0][31:0]  rsp_rdata;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    alias_regbank uut (
        .clk(clk), .rst_n(rst_n),
        .m_valid(m_valid), .m_write(m_write), .m_secure(m_secure),
        .m_addr(m_addr), .m_wdata(m_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access on master m; returns the response seen one cycle later
    task automatic acc(input int m, input bit wr, input bit sec, input logic [15:0] a,
                       input logic [31:0] d, output logic e, output logic [31:0] rd,
                       output logic v);
        @(negedge clk);
        m_valid[m] = 1'b1; m_write[m] = wr; m_secure[m] = sec;
        m_addr[m] = a; m_wdata[m] = d;
        @(negedge clk);
        v = rsp_valid[m]; e = rsp_err[m]; rd = rsp_rdata[m];
        m_valid[m] = 1'b0;
    endtask

    task automatic wr_ok(input string req, input logic [15:0] a, input logic [31:0] d);
        logic e, v; logic [31:0] rd;
        acc(0, 1'b1, 1'b1, a, d, e, rd, v);
        check({req, " write err"}, {31'd0, e}, 32'd0);
    endtask

    task automatic wr_rej(input string req, input bit sec, input logic [15:0] a,
                          input logic [31:0] d);
        logic e, v; logic [31:0] rd;
        acc(0, 1'b1, sec, a, d, e, rd, v);
        check({req, " reject err"}, {31'd0, e}, 32'd1);
    endtask

    task automatic rd_chk(input string req, input bit sec, input logic [15:0] a,
                          input logic [31:0] exp_d, input logic exp_e);
        logic e, v; logic [31:0] rd;
        acc(1, 1'b0, sec, a, 32'd0, e, rd, v);
        check({req, " read err"}, {31'd0, e}, {31'd0, exp_e});
        check({req, " read data"}, rd, exp_d);
    endtask

    task automatic t_reset;
        check("R1 rsp_valid after reset", {30'd0, rsp_valid}, 32'd0);
        for (int i = 0; i < 8; i++) rd_chk("R1 reset value", 1'b1, 16'(4*i), 32'd0, 1'b0);
    endtask

    task automatic t_plain;
        wr_ok("R2", 16'h0008, 32'hA5A5_0F0F);
        rd_chk("R2", 1'b1, 16'h0008, 32'hA5A5_0F0F, 1'b0);
        wr_ok("R2 low bits ignored", 16'h0007, 32'h0000_BEEF);
        rd_chk("R2 low bits ignored", 1'b1, 16'h0004, 32'h0000_BEEF, 1'b0);
    endtask

    task automatic t_set_clr;
        wr_ok("R3", 16'h0004, 32'h0000_00F0);
        wr_ok("R3", 16'hC004, 32'd31);
        rd_chk("R3 set bit 31", 1'b1, 16'h0004, 32'h8000_00F0, 1'b0);
        wr_ok("R3", 16'hC004, 32'd4);
        rd_chk("R3 set already set", 1'b1, 16'h0004, 32'h8000_00F0, 1'b0);
        wr_ok("R4", 16'h8004, 32'd7);
        rd_chk("R4 clear bit 7", 1'b1, 16'h0004, 32'h8000_0070, 1'b0);
        wr_ok("R4", 16'h8004, 32'd0);
        rd_chk("R4 clear already clear", 1'b1, 16'h0004, 32'h8000_0070, 1'b0);
    endtask

    task automatic t_big_index;
        wr_rej("R5 index 32", 1'b1, 16'hC004, 32'd32);
        wr_rej("R5 index huge", 1'b1, 16'h8004, 32'hFFFF_FFE4);
        rd_chk("R5 unchanged", 1'b1, 16'h0004, 32'h8000_0070, 1'b0);
    endtask

    task automatic t_noalias;
        wr_ok("R6 plain", 16'h0018, 32'h0000_0001);
        wr_rej("R6 set", 1'b1, 16'hC018, 32'd4);
        wr_rej("R6 clr", 1'b1, 16'h8018, 32'd0);
        rd_chk("R6 unchanged", 1'b1, 16'h0018, 32'h0000_0001, 1'b0);
    endtask

    task automatic t_secure;
        wr_rej("R7 plain", 1'b0, 16'h0008, 32'hFFFF_FFFF);
        wr_rej("R7 set", 1'b0, 16'hC008, 32'd1);
        rd_chk("R7 nonsecure read", 1'b0, 16'h0008, 32'hA5A5_0F0F, 1'b0);
    endtask

    task automatic t_ro;
        wr_rej("R8 plain", 1'b1, 16'h001C, 32'h0000_DEAD);
        wr_rej("R8 set", 1'b1, 16'hC01C, 32'd3);
        rd_chk("R8 stays zero", 1'b1, 16'h001C, 32'd0, 1'b0);
    endtask

    task automatic t_alias_read;
        rd_chk("R9 read via set alias", 1'b0, 16'hC008, 32'hA5A5_0F0F, 1'b0);
        rd_chk("R9 read via clr alias", 1'b1, 16'h8008, 32'hA5A5_0F0F, 1'b0);
        rd_chk("R9 reserved alias", 1'b1, 16'h4008, 32'd0, 1'b1);
        rd_chk("R9 unmapped read", 1'b1, 16'h0020, 32'd0, 1'b1);
        wr_rej("R9 unmapped write", 1'b1, 16'h0020, 32'h1234_5678);
        wr_rej("R9 reserved write", 1'b1, 16'h4000, 32'h1234_5678);
        rd_chk("R9 reg0 untouched", 1'b1, 16'h0000, 32'd0, 1'b0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        m_valid = 2'b11; m_write = 2'b01; m_secure = 2'b11;
        m_addr[0] = 16'h000C; m_wdata[0] = 32'h0000_1234;
        m_addr[1] = 16'h000C; m_wdata[1] = 32'd0;
        @(negedge clk);
        check("R10 both valid", {30'd0, rsp_valid}, 32'd3);
        check("R10 read sees old value", rsp_rdata[1], 32'd0);
        m_valid = 2'b00;
        @(negedge clk);
        check("R10 valid drops", {30'd0, rsp_valid}, 32'd0);
        rd_chk("R10 new value", 1'b1, 16'h000C, 32'h0000_1234, 1'b0);
    endtask

    task automatic dual(input logic [15:0] a0, input logic [31:0] d0,
                        input logic [15:0] a1, input logic [31:0] d1);
        @(negedge clk);
        m_valid = 2'b11; m_write = 2'b11; m_secure = 2'b11;
        m_addr[0] = a0; m_wdata[0] = d0; m_addr[1] = a1; m_wdata[1] = d1;
        @(negedge clk);
        check("R11 no error", {30'd0, rsp_err}, 32'd0);
        m_valid = 2'b00;
    endtask

    task automatic t_dual;
        dual(16'hC010, 32'd3, 16'hC010, 32'd9);
        rd_chk("R11 both sets land", 1'b1, 16'h0010, 32'h0000_0208, 1'b0);
        dual(16'h8010, 32'd3, 16'hC010, 32'd0);
        rd_chk("R11 clr and set land", 1'b1, 16'h0010, 32'h0000_0201, 1'b0);
        dual(16'h0010, 32'h0000_1111, 16'h0010, 32'h0000_2222);
        rd_chk("R11 master 1 plain last", 1'b1, 16'h0010, 32'h0000_2222, 1'b0);
        dual(16'h0010, 32'h0000_00F0, 16'hC010, 32'd0);
        rd_chk("R11 plain then set", 1'b1, 16'h0010, 32'h0000_00F1, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_set_clr();
        t_big_index();
        t_noalias();
        t_secure();
        t_ro();
        t_alias_read();
        t_timing();
        t_dual();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule